// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block holds three independent down-counting timers behind a small synchronous register port. Each channel keeps a 32-bit count, a reload value and a control word. The control word picks one of five divided versions of the block clock as the count rate. It also holds an interrupt enable and a sticky underflow flag. A shared start register runs or stops each channel.

When a running channel is at zero and its selected rate ticks, the channel reloads from its reload value and sets its flag. Its interrupt line stays high for as long as both the flag and the enable are set. Software clears the flag by writing zero to that bit. The count sequence is N, N-1, ..., 0 and then back to the reload value R. After the first pass, a channel therefore underflows once every (R+1) ticks. For example, a divide-by-1024 rate with R = 0x9896 on a 40 MHz clock gives about one underflow per second.

Top module: `interval_timer`

## Requirements
- R1: The start register at offset 0x04 runs channel c while bit c is 1 (c = 0, 1, 2). All other bits of that register read as zero.
- R2: A running channel whose count is not zero decrements by one on each tick of its selected rate.
- R3: A running channel whose count is zero reloads the reload value on a tick. This event is an underflow.
- R4: Control bit 8 is the flag. An underflow sets it. A control write with bit 8 = 0 clears it, and a write with bit 8 = 1 leaves it unchanged. If an underflow and a clearing write fall in the same cycle, the flag ends up set.
- R5: irq[c] is 1 exactly while both the flag and control bit 5 (enable) of channel c are 1.
- R6: Control bits 2:0 select the rate: 000 = /4, 001 = /16, 010 = /64, 011 = /256, 100 = /1024. The tick for select k comes when the low 2k+2 bits of a free-running 10-bit cycle counter are all ones. That counter is zero in the first cycle after reset. Codes 101 to 111 never tick, so the count holds.
- R7: A stopped channel holds its count. A write to the count register loads the written value at any time, and takes precedence over a decrement or reload in the same cycle.
- R8: The registers of channel c are at 0x08+12c (reload), 0x0C+12c (count) and 0x10+12c (control). The control register reads back select in bits 2:0, enable in bit 5 and flag in bit 8, with zeros elsewhere. Unmapped offsets read as zero and ignore writes.
- R9: While rst_n is low, every register is zero and irq is zero. The internal reset releases on the second rising clock edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the count rates |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 3 | Per-channel underflow interrupt request |

## Verification
The hardest case to reach is a flag-clearing control write that lands in the same cycle as an underflow. This matters because the underflow must win. To reach it, the bench sets a channel to the fastest rate with a zero count and a zero reload, so the channel underflows on every tick. It then issues the clearing write at each of eight successive phases of the divider, so exactly one phase in every four collides. Random traffic with small count and reload values, and with reserved select codes, makes many more collisions with writes to the count and reload registers.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned N_DIV     = 5;
  localparam int unsigned DIV_W     = 2 * N_DIV;
  localparam int unsigned OFF_START = 8'h04;
  localparam int unsigned OFF_CH0   = 8'h08;
  localparam int unsigned CH_STRIDE = 8'h0C;
  localparam int unsigned OFF_CNT   = 4;
  localparam int unsigned OFF_CTL   = 8;
  localparam int unsigned IE_BIT    = 5;
  localparam int unsigned FLAG_BIT  = 8;
endpackage

// File: rtl/itimer_prescaler.sv
module itimer_prescaler
  import itimer_pkg::*;
#(
  parameter int unsigned NDIV = N_DIV
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NDIV-1:0] tick
);
  localparam int unsigned W = 2 * NDIV;

  logic [W-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // tick k: low 2k+2 bits all ones -> one pulse every 4^(k+1) cycles
  for (genvar k = 0; k < NDIV; k++) begin : g_tick
    assign tick[k] = &div_q[2*k+1:0];
  end

  AST_TICK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    tick[NDIV-1] |-> tick[0]); // R6
endmodule

// File: rtl/itimer_channel.sv
module itimer_channel
  import itimer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NDIV  = N_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NDIV-1:0]  tick_vec,
  input  logic             con_we,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] con_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             ie_q,
  output logic             flag_q,
  output logic             irq
);
  logic [CNT_W-1:0] con_d, cnt_d;
  logic [SEL_W-1:0] sel_d;
  logic             ie_d, flag_d;
  logic             rate_tick, step, uf;

  // rate select; reserved codes match no entry and never tick
  always_comb begin
    rate_tick = 1'b0;
    for (int k = 0; k < NDIV; k++) begin
      if (sel_q == SEL_W'(k)) rate_tick = tick_vec[k];
    end
  end

  assign step = run & rate_tick;
  assign uf   = step & (cnt_q == '0);

  always_comb begin
    con_d  = con_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    ie_d   = ie_q;
    flag_d = flag_q;
    if (con_we) con_d = wdata;
    if (cnt_we)    cnt_d = wdata;
    else if (uf)   cnt_d = con_q;
    else if (step) cnt_d = cnt_q - CNT_W'(1);
    if (ctl_we) begin
      sel_d = wdata[SEL_W-1:0];
      ie_d  = wdata[IE_BIT];
    end
    if (uf)                            flag_d = 1'b1;
    else if (ctl_we && !wdata[FLAG_BIT]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      con_q  <= '0;
      cnt_q  <= '0;
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      con_q  <= con_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q & ie_q;

  AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> flag_q); // R4
  AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ctl_we && !wdata[FLAG_BIT])); // R4
  AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !cnt_we) |=> (cnt_q == $past(con_q))); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [N_CH-1:0]   irq
);
  localparam int unsigned N_HIT = 3 * N_CH + 1;

  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  logic [N_DIV-1:0] tick;
  itimer_prescaler #(.NDIV(N_DIV)) u_pre (
    .clk(clk), .rst_n(rst_i), .tick(tick)
  );

  logic start_hit, start_we;
  logic [N_CH-1:0] run_q, run_d;
  assign start_hit = (addr == ADDR_W'(OFF_START));
  assign start_we  = wr_en & start_hit;

  always_comb begin
    run_d = run_q;
    if (start_we) run_d = wdata[N_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) run_q <= '0;
    else        run_q <= run_d;
  end

  logic [N_CH-1:0]  con_hit, cnt_hit, ctl_hit;
  logic [CNT_W-1:0] con_a [N_CH];
  logic [CNT_W-1:0] cnt_a [N_CH];
  logic [SEL_W-1:0] sel_a [N_CH];
  logic [N_CH-1:0]  ie_a, flag_a;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(OFF_CH0 + c * CH_STRIDE);
    assign con_hit[c] = (addr == BASE);
    assign cnt_hit[c] = (addr == BASE + ADDR_W'(OFF_CNT));
    assign ctl_hit[c] = (addr == BASE + ADDR_W'(OFF_CTL));

    itimer_channel #(.CNT_W(CNT_W), .NDIV(N_DIV)) u_ch (
      .clk(clk), .rst_n(rst_i), .run(run_q[c]), .tick_vec(tick),
      .con_we(wr_en & con_hit[c]), .cnt_we(wr_en & cnt_hit[c]),
      .ctl_we(wr_en & ctl_hit[c]), .wdata(wdata),
      .con_q(con_a[c]), .cnt_q(cnt_a[c]), .sel_q(sel_a[c]),
      .ie_q(ie_a[c]), .flag_q(flag_a[c]), .irq(irq[c])
    );
  end

  always_comb begin
    rdata = '0;
    if (start_hit) rdata = CNT_W'(run_q);
    for (int c = 0; c < N_CH; c++) begin
      if (con_hit[c]) rdata = con_a[c];
      if (cnt_hit[c]) rdata = cnt_a[c];
      if (ctl_hit[c]) begin
        rdata[SEL_W-1:0] = sel_a[c];
        rdata[IE_BIT]    = ie_a[c];
        rdata[FLAG_BIT]  = flag_a[c];
      end
    end
  end

  logic [N_HIT-1:0] hit_vec;
  assign hit_vec = {con_hit, cnt_hit, ctl_hit, start_hit};

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(hit_vec)); // R8
  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_i)
    start_we |=> (run_q == $past(wdata[N_CH-1:0]))); // R1
endmodule

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_con [NCH];
  logic [31:0] m_cnt [NCH];
  logic [2:0]  m_sel [NCH];
  logic        m_ie  [NCH];
  logic        m_flag[NCH];
  logic [2:0]  m_run;
  logic [9:0]  m_div;
  logic        m_s1, m_s2;

  function automatic logic [7:0] base_of(int c);
    return 8'(8 + 12 * c);
  endfunction

  function automatic logic rate_tick(logic [2:0] sel, logic [9:0] dv);
    logic [9:0] mask;
    if (sel > 3'd4) return 1'b0;
    mask = 10'((1 << (2 * int'(sel) + 2)) - 1);
    return (dv & mask) == mask;
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    logic [31:0] r;
    r = 32'h0;
    if (a == 8'h04) r = {29'h0, m_run};
    for (int c = 0; c < NCH; c++) begin
      if (a == base_of(c))     r = m_con[c];
      if (a == base_of(c) + 4) r = m_cnt[c];
      if (a == base_of(c) + 8) r = {23'h0, m_flag[c], 2'b0, m_ie[c], 2'b0, m_sel[c]};
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_run = 0; m_div = 0;
      for (int c = 0; c < NCH; c++) begin
        m_con[c] = 0; m_cnt[c] = 0; m_sel[c] = 0; m_ie[c] = 0; m_flag[c] = 0;
      end
    end else begin
      if (m_s2) begin
        for (int c = 0; c < NCH; c++) begin
          logic st, uf;
          st = m_run[c] && rate_tick(m_sel[c], m_div);
          uf = st && (m_cnt[c] == 0);
          if (wr_en && addr == base_of(c) + 4) m_cnt[c] = wdata;
          else if (uf) m_cnt[c] = m_con[c];
          else if (st) m_cnt[c] = m_cnt[c] - 1;
          if (uf) m_flag[c] = 1;
          else if (wr_en && addr == base_of(c) + 8 && !wdata[8]) m_flag[c] = 0;
          if (wr_en && addr == base_of(c) + 8) begin
            m_sel[c] = wdata[2:0]; m_ie[c] = wdata[5];
          end
          if (wr_en && addr == base_of(c)) m_con[c] = wdata;
        end
        if (wr_en && addr == 8'h04) m_run = wdata[2:0];
        m_div = m_div + 1;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, string tag);
    @(negedge clk);
    addr = a;
    #0.5;
    chk(tag, rdata, mread(a));
    chk("R5 irq", {29'h0, irq}, {29'h0, m_flag[2] & m_ie[2], m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle(3);
    // R9: registers zero during reset
    chk("R9 irq in reset", {29'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1;
    idle(3);
    rd_chk(8'h04, "R9 start reset");
    for (int c = 0; c < NCH; c++) begin
      rd_chk(base_of(c), "R9 reload reset");
      rd_chk(base_of(c) + 4, "R9 count reset");
      rd_chk(base_of(c) + 8, "R9 ctl reset");
    end

    // R1: reserved start bits
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, "R1 start reserved");
    chk("R1 start value", rdata, 32'h7);
    wr(8'h04, 32'h0);

    // R8: unmapped offsets
    wr(8'h00, 32'hDEAD_BEEF);
    rd_chk(8'h00, "R8 unmapped 0x00");
    rd_chk(8'h30, "R8 unmapped 0x30");

    // R7: stopped hold, direct load
    wr(8'h0C, 32'd5);
    idle(40);
    rd_chk(8'h0C, "R7 stopped hold");
    chk("R7 count value", rdata, 32'd5);

    // R2, R3: run ch0 at /4, reload 3
    wr(8'h08, 32'd3);
    wr(8'h10, 32'h0);
    wr(8'h04, 32'h1);
    for (int i = 0; i < 12; i++) begin
      idle(2);
      rd_chk(8'h0C, "R2 decrement");
      rd_chk(8'h10, "R4 flag set");
    end
    // R5: enable raises irq
    wr(8'h10, 32'h120);
    rd_chk(8'h10, "R5 enable");
    // R4: writing 1 to flag leaves it
    wr(8'h04, 32'h0);
    wr(8'h10, 32'h120);
    rd_chk(8'h10, "R4 write one keeps flag");
    wr(8'h10, 32'h020);
    rd_chk(8'h10, "R4 write zero clears flag");

    // R6: reserved code holds while running
    wr(8'h18, 32'd9);
    wr(8'h1C, 32'h5);
    wr(8'h04, 32'h2);
    idle(50);
    rd_chk(8'h18, "R6 reserved select holds");
    chk("R6 hold value", rdata, 32'd9);

    // R6: /1024 on ch2, /256 on ch1
    wr(8'h24, 32'd2);
    wr(8'h20, 32'd2);
    wr(8'h28, 32'h24);
    wr(8'h1C, 32'h3);
    wr(8'h04, 32'h6);
    for (int i = 0; i < 16; i++) begin
      idle(250);
      rd_chk(8'h24, "R6 div1024 count");
      rd_chk(8'h18, "R6 div256 count");
      rd_chk(8'h28, "R6 div1024 flag");
    end
    wr(8'h04, 32'h0);

    // R4: clear colliding with underflow, swept over phases
    wr(8'h08, 32'd0);
    wr(8'h0C, 32'd0);
    wr(8'h10, 32'h20);
    wr(8'h04, 32'h1);
    for (int p = 0; p < 8; p++) begin
      idle(p);
      wr(8'h10, 32'h20);
      rd_chk(8'h10, "R4 clear vs underflow");
    end
    wr(8'h04, 32'h0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int c;
      int kind;
      logic [31:0] d;
      c = int'($urandom_range(0, NCH - 1));
      kind = int'($urandom_range(0, 5));
      d = $urandom;
      case (kind)
        0: wr(8'h04, d & 32'hFF);
        1: wr(base_of(c), d & 32'h1F);
        2: wr(base_of(c) + 4, d & 32'h1F);
        3: wr(base_of(c) + 8, d & 32'h1FF);
        default: idle(int'(d & 32'h7));
      endcase
      case ($urandom_range(0, 3))
        0: rd_chk(8'h04, "R1 random start");
        1: rd_chk(base_of(c), "R8 random reload");
        2: rd_chk(base_of(c) + 4, "R2 R3 R7 random count");
        default: rd_chk(base_of(c) + 8, "R4 R6 random ctl");
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule